// File: doc/BRIEF.md
# Far Call Protection Checker

This block decides what a protected-mode far call may do before any state is touched. It takes the target selector, the access-rights byte of the descriptor that the selector names, and the current privilege level. When the target is a gate, it also takes the inner selector that the gate carries and the access-rights byte of the descriptor that inner selector names. It also takes the limits of the global and local descriptor tables.

From these it picks the control-transfer path. It evaluates the privilege, presence and type rules that belong to that path and reports the first failing rule as an exception class with an error-code selector. When every rule passes, it gives the code selector with its requested privilege bits already fixed up. For call gates it also flags whether the call enters a more privileged level.

The decision logic is combinational. One register stage holds the result, so a request presented in one cycle is answered in the next. A sequencer that performs the transfer, the task switch or the stack checks reads the registered verdict.

Top module: `far_call_gatekeeper`

## Requirements
- R1: Results appear one clock after a request. `out_valid` in a cycle equals `req_valid` in the previous cycle. In a cycle after no request, and throughout reset, every output is zero.
- R2: A target selector whose bits 15..2 are all zero is null. It reports exception GP with error code 0 and path 0 (none).
- R3: A selector has its index in bits 15..3, its table bit in bit 2 (0 = global, 1 = local) and its requested privilege in bits 1..0. It is in range only when index*8+7 does not exceed the limit of its table. An out-of-range target reports GP(target) with path 0.
- R4: Access-rights byte layout: bit 7 present, bits 6..5 DPL, bit 4 set for code/data, bits 3..0 type. The paths are as follows. Conforming code is bit 4 set with type bits 3 and 2 set (path 1). Nonconforming code is bit 4 set with type bit 3 set and bit 2 clear (path 2). A call gate is bit 4 clear with type 4 or 12 (path 3). A task gate is bit 4 clear with type 5 (path 4). A task state segment is bit 4 clear with type 1, 3, 9 or 11 (path 5). Any other value reports GP(target) with path 0.
- R5: On a conforming target, a DPL above CPL gives GP(target). If the DPL is allowed but the segment is absent, the result is NP(target). If both rules pass, the code selector is the target selector unchanged.
- R6: On a nonconforming target, GP(target) is reported when the RPL is above CPL or the DPL differs from CPL. Otherwise an absent segment gives NP(target). Otherwise the code selector is the target with bits 1..0 replaced by CPL.
- R7: On a call gate, GP(target) is reported when the gate DPL is below CPL or below the RPL. Otherwise an absent gate gives NP(target).
- R8: For a call gate's inner selector, the checks run in this order. A null inner selector gives GP with error code 0. An index beyond its table limit gives GP(inner). An inner descriptor that is not code gives GP(inner). An inner DPL above CPL gives GP(inner). An absent inner segment gives NP(inner).
- R9: A call gate that passes leads to nonconforming code with a DPL below CPL, or to other code. In the first case `out_more_priv` is 1 and the code selector is the inner selector with RPL set to the code DPL. In the second case `out_more_priv` is 0 and the RPL is set to CPL.
- R10: On a task gate, the checks run in this order. A gate DPL below CPL or below the RPL gives TS(target). An absent gate gives NP(target). A local inner selector gives TS(inner). An inner index beyond the global limit gives TS(inner). An inner descriptor that is not an available TSS (bit 4 clear, type 1 or 9) gives TS(inner). An absent TSS gives NP(inner).
- R11: On a direct TSS target, the checks run in this order. A DPL below CPL or below the RPL gives TS(target). A busy TSS (type 3 or 11) gives TS(target). An absent TSS gives NP(target).
- R12: Exception codes are 0 none, 1 GP, 2 NP, 3 TS. A selector error code is the selector with bits 1..0 cleared. With no exception the error code is 0. The code selector output is 0 for task paths and for any exception. `out_more_priv` is 0 unless a call gate passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| tgt_sel | input | 16 | Target selector from the far pointer |
| tgt_ar | input | 8 | Access-rights byte of the target descriptor |
| inner_sel | input | 16 | Selector held inside a gate descriptor |
| inner_ar | input | 8 | Access-rights byte of the descriptor named by inner_sel |
| gdt_limit | input | 16 | Byte limit of the global descriptor table |
| ldt_limit | input | 16 | Byte limit of the local descriptor table |
| cpl | input | 2 | Current privilege level |
| out_valid | output | 1 | Registered result is valid |
| out_path | output | 3 | Chosen path code |
| out_more_priv | output | 1 | Call gate enters a more privileged level |
| out_exc | output | 2 | Exception class |
| out_err | output | 16 | Error-code selector |
| out_cs_sel | output | 16 | Resulting code selector on success |

## Verification
Directed vectors walk each path through its rules one at a time. Each vector passes every earlier rule and breaks exactly one, so the reported class and error selector show that the priority order is right and that the error names the correct selector (target, inner, or zero). Boundary vectors put indices exactly at and one past each table limit. Equal, lower and higher DPL/RPL/CPL combinations separate strict from non-strict comparisons. Random traffic with mostly present descriptors and a spread of type codes then mixes paths and privilege levels. It is compared every cycle against a behavioural model, which also covers idle cycles and reset.

// File: rtl/far_call_gatekeeper.sv
module far_call_gatekeeper (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [15:0] tgt_sel,
  input  logic [7:0]  tgt_ar,
  input  logic [15:0] inner_sel,
  input  logic [7:0]  inner_ar,
  input  logic [15:0] gdt_limit,
  input  logic [15:0] ldt_limit,
  input  logic [1:0]  cpl,
  output logic        out_valid,
  output logic [2:0]  out_path,
  output logic        out_more_priv,
  output logic [1:0]  out_exc,
  output logic [15:0] out_err,
  output logic [15:0] out_cs_sel
);
  localparam logic [2:0] PATH_NONE = 3'd0, PATH_CONF = 3'd1, PATH_NCONF = 3'd2,
                         PATH_CGATE = 3'd3, PATH_TGATE = 3'd4, PATH_TSS = 3'd5;
  localparam logic [1:0] EX_NONE = 2'd0, EX_GP = 2'd1, EX_NP = 2'd2, EX_TS = 2'd3;

  function automatic logic fits(input logic [15:0] s, input logic [15:0] gl, input logic [15:0] ll);
    return {s[15:3], 3'b111} <= (s[2] ? ll : gl);
  endfunction

  logic [1:0]  t_dpl, t_rpl, i_dpl;
  logic        t_p, i_p, t_sys, i_sys;
  logic [3:0]  t_typ, i_typ;
  logic [15:0] t_err, i_err;

  assign t_p   = tgt_ar[7];
  assign t_dpl = tgt_ar[6:5];
  assign t_sys = ~tgt_ar[4];
  assign t_typ = tgt_ar[3:0];
  assign t_rpl = tgt_sel[1:0];
  assign i_p   = inner_ar[7];
  assign i_dpl = inner_ar[6:5];
  assign i_sys = ~inner_ar[4];
  assign i_typ = inner_ar[3:0];
  assign t_err = {tgt_sel[15:2], 2'b00};
  assign i_err = {inner_sel[15:2], 2'b00};

  logic is_conf, is_nconf, is_cgate, is_tgate, is_tss, i_code, i_nconf, i_avail_tss;
  assign is_conf     = ~t_sys & t_typ[3] & t_typ[2];
  assign is_nconf    = ~t_sys & t_typ[3] & ~t_typ[2];
  assign is_cgate    = t_sys & (t_typ[2:0] == 3'b100);
  assign is_tgate    = t_sys & (t_typ == 4'd5);
  assign is_tss      = t_sys & (t_typ[2:0] == 3'b001 || t_typ[2:0] == 3'b011);
  assign i_code      = ~i_sys & i_typ[3];
  assign i_nconf     = i_code & ~i_typ[2];
  assign i_avail_tss = i_sys & (i_typ[2:0] == 3'b001);

  logic [2:0]  n_path;
  logic [1:0]  n_exc;
  logic [15:0] n_err, n_cs;
  logic        n_mp;

  always_comb begin
    n_path = PATH_NONE;
    n_exc  = EX_NONE;
    n_err  = '0;
    n_cs   = '0;
    n_mp   = 1'b0;
    if (tgt_sel[15:2] == '0) begin
      n_exc = EX_GP;
    end else if (!fits(tgt_sel, gdt_limit, ldt_limit)) begin
      n_exc = EX_GP;
      n_err = t_err;
    end else if (is_conf) begin
      n_path = PATH_CONF;
      if (t_dpl > cpl)      begin n_exc = EX_GP; n_err = t_err; end
      else if (!t_p)        begin n_exc = EX_NP; n_err = t_err; end
      else                  n_cs = tgt_sel;
    end else if (is_nconf) begin
      n_path = PATH_NCONF;
      if (t_rpl > cpl || t_dpl != cpl) begin n_exc = EX_GP; n_err = t_err; end
      else if (!t_p)                   begin n_exc = EX_NP; n_err = t_err; end
      else                             n_cs = {tgt_sel[15:2], cpl};
    end else if (is_cgate) begin
      n_path = PATH_CGATE;
      if (t_dpl < cpl || t_dpl < t_rpl)           begin n_exc = EX_GP; n_err = t_err; end
      else if (!t_p)                              begin n_exc = EX_NP; n_err = t_err; end
      else if (inner_sel[15:2] == '0)             n_exc = EX_GP;
      else if (!fits(inner_sel, gdt_limit, ldt_limit)) begin n_exc = EX_GP; n_err = i_err; end
      else if (!i_code)                           begin n_exc = EX_GP; n_err = i_err; end
      else if (i_dpl > cpl)                       begin n_exc = EX_GP; n_err = i_err; end
      else if (!i_p)                              begin n_exc = EX_NP; n_err = i_err; end
      else if (i_nconf && i_dpl < cpl) begin
        n_mp = 1'b1;
        n_cs = {inner_sel[15:2], i_dpl};
      end else begin
        n_cs = {inner_sel[15:2], cpl};
      end
    end else if (is_tgate) begin
      n_path = PATH_TGATE;
      if (t_dpl < cpl || t_dpl < t_rpl)           begin n_exc = EX_TS; n_err = t_err; end
      else if (!t_p)                              begin n_exc = EX_NP; n_err = t_err; end
      else if (inner_sel[2])                      begin n_exc = EX_TS; n_err = i_err; end
      else if (!fits(inner_sel, gdt_limit, ldt_limit)) begin n_exc = EX_TS; n_err = i_err; end
      else if (!i_avail_tss)                      begin n_exc = EX_TS; n_err = i_err; end
      else if (!i_p)                              begin n_exc = EX_NP; n_err = i_err; end
    end else if (is_tss) begin
      n_path = PATH_TSS;
      if (t_dpl < cpl || t_dpl < t_rpl) begin n_exc = EX_TS; n_err = t_err; end
      else if (t_typ[1])                begin n_exc = EX_TS; n_err = t_err; end
      else if (!t_p)                    begin n_exc = EX_NP; n_err = t_err; end
    end else begin
      n_exc = EX_GP;
      n_err = t_err;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      out_valid     <= 1'b0;
      out_path      <= PATH_NONE;
      out_more_priv <= 1'b0;
      out_exc       <= EX_NONE;
      out_err       <= '0;
      out_cs_sel    <= '0;
    end else begin
      out_valid     <= 1'b1;
      out_path      <= n_path;
      out_more_priv <= n_mp;
      out_exc       <= n_exc;
      out_err       <= n_err;
      out_cs_sel    <= n_cs;
    end
  end
endmodule

// File: rtl/far_call_gatekeeper_chk.sv
module far_call_gatekeeper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [15:0] tgt_sel,
  input logic [1:0]  cpl,
  input logic        out_valid,
  input logic [2:0]  out_path,
  input logic        out_more_priv,
  input logic [1:0]  out_exc,
  input logic [15:0] out_err,
  input logic [15:0] out_cs_sel
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && out_exc == 2'd0 && out_path == 3'd0));
  p_null_gp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tgt_sel[15:2] == 14'd0) |=> (out_exc == 2'd1 && out_err == 16'd0 && out_path == 3'd0));
  p_nconf_rpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!(out_path == 3'd2 && out_exc == 2'd0) || out_cs_sel[1:0] == $past(cpl)));
  p_more_priv_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_more_priv |-> (out_path == 3'd3 && out_exc == 2'd0));
  p_task_no_gp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_path == 3'd4 || out_path == 3'd5)) |-> (out_exc != 2'd1 && out_cs_sel == 16'd0));
  p_clean_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exc == 2'd0) |-> (out_err == 16'd0));
  p_err_low_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_err[1:0] == 2'b00));
endmodule

bind far_call_gatekeeper far_call_gatekeeper_chk chk_i (.*);

// File: tb/far_call_gatekeeper_tb_top.sv
module far_call_gatekeeper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] tgt_sel = '0, inner_sel = '0;
  logic [7:0]  tgt_ar = '0, inner_ar = '0;
  logic [15:0] gdt_limit = 16'h00FF, ldt_limit = 16'h003F;
  logic [1:0]  cpl = '0;
  logic        out_valid, out_more_priv;
  logic [2:0]  out_path;
  logic [1:0]  out_exc;
  logic [15:0] out_err, out_cs_sel;

  always #5 clk = ~clk;

  far_call_gatekeeper dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string cur_tag = "R1";
  string exp_tag = "R1";
  int e_v, e_path, e_exc, e_err, e_cs, e_mp;

  task automatic model(input int s, input int a, input int is_, input int ia, input int c,
                       output int path, output int exc, output int err, output int cs, output int mp);
    int idx, rpl, lim, p, dpl, sys, typ;
    int iidx, ilim, ip, idpl, isys, ityp;
    idx = s / 8; rpl = s % 4; lim = ((s / 4) % 2 == 1) ? int'(ldt_limit) : int'(gdt_limit);
    p = a / 128; dpl = (a / 32) % 4; sys = ((a / 16) % 2 == 0); typ = a % 16;
    iidx = is_ / 8; ilim = ((is_ / 4) % 2 == 1) ? int'(ldt_limit) : int'(gdt_limit);
    ip = ia / 128; idpl = (ia / 32) % 4; isys = ((ia / 16) % 2 == 0); ityp = ia % 16;
    path = 0; exc = 0; err = 0; cs = 0; mp = 0;
    if (s / 4 == 0) begin exc = 1; return; end
    if (idx * 8 + 7 > lim) begin exc = 1; err = s - rpl; return; end
    if (!sys && typ >= 12) begin
      path = 1;
      if (dpl > c) begin exc = 1; err = s - rpl; end
      else if (p == 0) begin exc = 2; err = s - rpl; end
      else cs = s;
    end else if (!sys && typ >= 8) begin
      path = 2;
      if (rpl > c || dpl != c) begin exc = 1; err = s - rpl; end
      else if (p == 0) begin exc = 2; err = s - rpl; end
      else cs = s - rpl + c;
    end else if (sys && (typ == 4 || typ == 12)) begin
      path = 3;
      if (dpl < c || dpl < rpl) begin exc = 1; err = s - rpl; end
      else if (p == 0) begin exc = 2; err = s - rpl; end
      else if (is_ / 4 == 0) exc = 1;
      else if (iidx * 8 + 7 > ilim) begin exc = 1; err = is_ - is_ % 4; end
      else if (isys || ityp < 8) begin exc = 1; err = is_ - is_ % 4; end
      else if (idpl > c) begin exc = 1; err = is_ - is_ % 4; end
      else if (ip == 0) begin exc = 2; err = is_ - is_ % 4; end
      else if (ityp < 12 && idpl < c) begin mp = 1; cs = is_ - is_ % 4 + idpl; end
      else cs = is_ - is_ % 4 + c;
    end else if (sys && typ == 5) begin
      path = 4;
      if (dpl < c || dpl < rpl) begin exc = 3; err = s - rpl; end
      else if (p == 0) begin exc = 2; err = s - rpl; end
      else if ((is_ / 4) % 2 == 1) begin exc = 3; err = is_ - is_ % 4; end
      else if (iidx * 8 + 7 > int'(gdt_limit)) begin exc = 3; err = is_ - is_ % 4; end
      else if (!(isys && (ityp == 1 || ityp == 9))) begin exc = 3; err = is_ - is_ % 4; end
      else if (ip == 0) begin exc = 2; err = is_ - is_ % 4; end
    end else if (sys && (typ == 1 || typ == 3 || typ == 9 || typ == 11)) begin
      path = 5;
      if (dpl < c || dpl < rpl) begin exc = 3; err = s - rpl; end
      else if (typ == 3 || typ == 11) begin exc = 3; err = s - rpl; end
      else if (p == 0) begin exc = 2; err = s - rpl; end
    end else begin
      exc = 1; err = s - rpl;
    end
  endtask

  always @(posedge clk) begin
    exp_tag = cur_tag;
    if (!rst_n || !req_valid) begin
      e_v = 0; e_path = 0; e_exc = 0; e_err = 0; e_cs = 0; e_mp = 0;
    end else begin
      e_v = 1;
      model(int'(tgt_sel), int'(tgt_ar), int'(inner_sel), int'(inner_ar), int'(cpl),
            e_path, e_exc, e_err, e_cs, e_mp);
    end
  end

  bit armed = 1'b0;
  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (int'(out_valid) != e_v || int'(out_path) != e_path || int'(out_exc) != e_exc ||
          int'(out_err) != e_err || int'(out_cs_sel) != e_cs || int'(out_more_priv) != e_mp) begin
        errors++;
        $display("FAIL %s actual v=%0d path=%0d exc=%0d err=%h cs=%h mp=%0d expected v=%0d path=%0d exc=%0d err=%h cs=%h mp=%0d",
                 exp_tag, out_valid, out_path, out_exc, out_err, out_cs_sel, out_more_priv,
                 e_v, e_path, e_exc, e_err, e_cs, e_mp);
      end
    end
  end

  task automatic go(input string tag, input logic [15:0] s, input logic [7:0] a,
                    input logic [15:0] is_, input logic [7:0] ia, input logic [1:0] c);
    @(negedge clk);
    cur_tag = tag; req_valid = 1'b1;
    tgt_sel = s; tgt_ar = a; inner_sel = is_; inner_ar = ia; cpl = c;
  endtask

  function automatic logic [7:0] ar(input bit p, input int dpl, input bit seg, input int typ);
    return {p, 2'(dpl), seg, 4'(typ)};
  endfunction

  initial begin
    @(negedge clk); armed = 1'b1; cur_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    go("R2", 16'h0003, ar(1,0,1,10), 16'h0, 8'h0, 0);
    go("R3", 16'h0140, ar(1,0,1,10), 16'h0, 8'h0, 0);
    go("R3", 16'h0044, ar(1,0,1,10), 16'h0, 8'h0, 0);
    go("R3", 16'h00F8, ar(1,0,1,10), 16'h0, 8'h0, 0);
    go("R3", 16'h003C, ar(1,0,1,10), 16'h0, 8'h0, 0);
    go("R4", 16'h0010, ar(1,0,1,2), 16'h0, 8'h0, 0);
    go("R4", 16'h0010, ar(1,3,0,2), 16'h0, 8'h0, 0);
    go("R5", 16'h0013, ar(1,3,1,14), 16'h0, 8'h0, 0);
    go("R5", 16'h0013, ar(1,0,1,14), 16'h0, 8'h0, 3);
    go("R5", 16'h0013, ar(0,1,1,14), 16'h0, 8'h0, 1);
    go("R6", 16'h0013, ar(1,1,1,10), 16'h0, 8'h0, 1);
    go("R6", 16'h0011, ar(1,2,1,10), 16'h0, 8'h0, 1);
    go("R6", 16'h0010, ar(0,1,1,10), 16'h0, 8'h0, 1);
    go("R6", 16'h0010, ar(1,2,1,10), 16'h0, 8'h0, 2);
    go("R7", 16'h0018, ar(1,1,0,12), 16'h0020, ar(1,0,1,10), 2);
    go("R7", 16'h001B, ar(1,2,0,12), 16'h0020, ar(1,0,1,10), 2);
    go("R7", 16'h0018, ar(0,3,0,4), 16'h0020, ar(1,0,1,10), 2);
    go("R8", 16'h0018, ar(1,3,0,12), 16'h0003, ar(1,0,1,10), 2);
    go("R8", 16'h0018, ar(1,3,0,12), 16'h0104, ar(1,0,1,10), 2);
    go("R8", 16'h0018, ar(1,3,0,12), 16'h0020, ar(1,0,1,2), 2);
    go("R8", 16'h0018, ar(1,3,0,12), 16'h0020, ar(1,3,1,10), 2);
    go("R8", 16'h0018, ar(1,3,0,12), 16'h0020, ar(0,0,1,10), 2);
    go("R9", 16'h0018, ar(1,3,0,12), 16'h0023, ar(1,0,1,10), 3);
    go("R9", 16'h0018, ar(1,3,0,12), 16'h0023, ar(1,0,1,14), 3);
    go("R9", 16'h0018, ar(1,3,0,12), 16'h0021, ar(1,2,1,10), 2);
    go("R10", 16'h0028, ar(1,0,0,5), 16'h0030, ar(1,0,0,9), 1);
    go("R10", 16'h0028, ar(0,3,0,5), 16'h0030, ar(1,0,0,9), 1);
    go("R10", 16'h0028, ar(1,3,0,5), 16'h0034, ar(1,0,0,9), 1);
    go("R10", 16'h0028, ar(1,3,0,5), 16'h0100, ar(1,0,0,9), 1);
    go("R10", 16'h0028, ar(1,3,0,5), 16'h0030, ar(1,0,0,11), 1);
    go("R10", 16'h0028, ar(1,3,0,5), 16'h0030, ar(0,0,0,1), 1);
    go("R10", 16'h0028, ar(1,3,0,5), 16'h0030, ar(1,0,0,9), 1);
    go("R11", 16'h0033, ar(1,2,0,9), 16'h0, 8'h0, 1);
    go("R11", 16'h0030, ar(1,2,0,11), 16'h0, 8'h0, 1);
    go("R11", 16'h0030, ar(0,2,0,1), 16'h0, 8'h0, 1);
    go("R11", 16'h0030, ar(1,2,0,9), 16'h0, 8'h0, 1);
    @(negedge clk); cur_tag = "R1"; req_valid = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] s, is_;
      logic [7:0]  a, ia;
      s   = {3'(0), 10'($urandom_range(0, 40)), 1'($urandom), 2'($urandom)};
      is_ = {3'(0), 10'($urandom_range(0, 40)), 1'($urandom % 4 == 0), 2'($urandom)};
      a   = ar($urandom % 10 != 0, $urandom % 4, $urandom % 2, $urandom % 16);
      ia  = ar($urandom % 10 != 0, $urandom % 4, $urandom % 2, $urandom % 16);
      if ($urandom % 8 == 0) begin
        @(negedge clk); cur_tag = "R1"; req_valid = 1'b0;
      end else begin
        go("R12", s, a, is_, ia, 2'($urandom));
      end
    end
    @(negedge clk); cur_tag = "R1"; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule